// File: doc/BRIEF.md
# Queued Write/Erase Operation Controller

This block sits behind a command decoder. It runs word writes, block erases and whole-array erases against a set of independently erasable blocks. Each block has a lock bit. A global write-protect input decides whether those lock bits are enforced. The controller holds one request in a pending slot while another operation runs, so the host does not have to wait for each operation to finish before sending the next one.

Two execution engines work side by side. The write engine runs word writes. The erase engine runs single-block erases and the sweep that erases all unlocked blocks. A word write to a block other than the one being erased can run while the erase is in progress, including while the erase is suspended. Operation lengths come from two programmable cycle-count inputs. Each engine gives a one-cycle strobe toward the memory model on the last cycle of its work. A power-down input stops all activity, empties the pending slot and clears every status flag. It does not change the lock bits.

Top module: `qop_ctrl`

## Requirements
- R1: After reset `ry_by_n` is 1, `req_ready` is 1, `status` is 8'h80, and neither `arr_we` nor `erase_stb` is asserted.
- R2: A write request (`req_op`=1) accepted at clock edge k gives exactly one `arr_we` pulse, in the cycle after edge k+`wr_cycles` (a value of 0 counts as 1). The pulse carries the request's block, address and data.
- R3: At most one request waits in the pending slot behind the running operations. `req_ready` is 0 in the cycle after an accept and stays 0 while the slot is full. `ry_by_n` stays 0 until the slot and both engines are empty.
- R4: With `wp_n`=0, a write or an erase (`req_op`=2) aimed at a locked block is refused. No strobe is issued, and status bits 5 (error) and 4 (lock violation) are set. These bits stay set.
- R5: With `wp_n`=1, writes and erases go ahead whatever the state of the lock bits.
- R6: An erase accepted at edge k gives one `erase_stb` pulse, with `erase_blk` equal to the target block, in the cycle after edge k+`er_cycles`+1.
- R7: The erase-all request (`req_op`=3) erases blocks in ascending order and gives one strobe for each block. When `wp_n`=0, locked blocks are skipped without a strobe.
- R8: A write to a block other than the one being erased starts while the erase runs. A write to the block under erase, or any write during an erase-all, waits until the erase has finished.
- R9: While `susp_req` is 1 and an erase is active, the erase countdown is frozen. Status bit 6 is 1, and `ry_by_n` is 1 when no write is running or pending. When `susp_req` drops, the erase continues from where it stopped.
- R10: While `rp_n` is 0, the running operations and the pending request are discarded, `req_ready` is 0, `ry_by_n` is 1 and `status` is 8'h80. No strobe follows. Lock bits are kept.
- R11: The clear-status request (`req_op`=6) clears status bits 5 and 4.
- R12: Undefined opcodes (0 and 7) set status bit 5 only and touch no block.
- R13: The set-lock request (`req_op`=4) locks the addressed block. The clear-locks request (`req_op`=5) unlocks every block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Pending slot free; request accepted when valid and ready |
| req_op | input | 3 | Operation code |
| req_blk | input | BW (5) | Target block |
| req_addr | input | AW (15) | Word address within block |
| req_data | input | DW (16) | Write data |
| wp_n | input | 1 | Write protect, active low; enforces lock bits |
| rp_n | input | 1 | Power-down/abort, active low |
| susp_req | input | 1 | Erase suspend request (level) |
| wr_cycles | input | CW (16) | Write duration in cycles |
| er_cycles | input | CW (16) | Per-block erase duration in cycles |
| ry_by_n | output | 1 | Ready (1) / busy (0) |
| status | output | 8 | {ready, erase-suspended, error, lock-violation, 4'b0} |
| lock_viol | output | 1 | Sticky lock-violation flag |
| busy | output | 1 | Work is running or pending |
| arr_we | output | 1 | Array word-write strobe |
| arr_blk | output | BW (5) | Write block |
| arr_addr | output | AW (15) | Write address |
| arr_data | output | DW (16) | Write data |
| erase_stb | output | 1 | Block erase strobe |
| erase_blk | output | BW (5) | Erased block |

## Verification
Single writes and erases on an idle controller pin down the exact latencies, which separates a wrong counter load or a missing select cycle from correct timing. Back-to-back writes fill the pending slot and show whether the ready handshake and the busy indication track the queue. Erase-then-write pairs to different blocks and to the same block show whether writes overlap erases only when they should. Locked-block requests with write protect low and high, an erase-all over a mix of locked blocks, a mid-erase suspend and an abort with work in flight each check one protection or ordering rule.

// File: rtl/qop_pkg.sv
package qop_pkg;

  typedef enum logic [2:0] {
    OP_RSV0      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_SET_LOCK  = 3'd4,
    OP_CLR_LOCKS = 3'd5,
    OP_CLR_STAT  = 3'd6,
    OP_RSV7      = 3'd7
  } op_e;

  // a block modification is refused when locked and protection is enforced
  function automatic logic refused(input logic locked, input logic wp_n);
    return locked & ~wp_n;
  endfunction

  function automatic logic hits_array(input op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE);
  endfunction

  function automatic logic undefined_op(input op_e op);
    return (op == OP_RSV0) || (op == OP_RSV7);
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy, input logic susp,
                                             input logic err, input logic lv);
    return {rdy, susp, err, lv, 4'b0000};
  endfunction

endpackage

// File: rtl/qop_timer.sv
module qop_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          hold,
  output logic          active,
  output logic          last
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (load)                  cnt <= (len == '0) ? ONE : len;
    else if (cnt != '0 && !hold)    cnt <= cnt - ONE;
  end

  assign active = (cnt != '0);
  assign last   = (cnt == ONE) && !hold;
endmodule

// File: rtl/qop_lockbank.sv
module qop_lockbank #(
  parameter int NBLK = 32,
  parameter int BW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [BW-1:0]   set_idx,
  input  logic            clr_all,
  output logic [NBLK-1:0] locks
);
  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               locks[g] <= 1'b0;
      else if (clr_all)                         locks[g] <= 1'b0;
      else if (set_en && set_idx == BW'(g))     locks[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/qop_ctrl.sv
module qop_ctrl
  import qop_pkg::*;
#(
  parameter int NBLK = 32,
  parameter int AW   = 15,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [BW-1:0] req_blk,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wp_n,
  input  logic          rp_n,
  input  logic          susp_req,
  input  logic [CW-1:0] wr_cycles,
  input  logic [CW-1:0] er_cycles,
  output logic          ry_by_n,
  output logic [7:0]    status,
  output logic          lock_viol,
  output logic          busy,
  output logic          arr_we,
  output logic [BW-1:0] arr_blk,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic          erase_stb,
  output logic [BW-1:0] erase_blk
);
  localparam logic [BW-1:0] LAST_BLK = BW'(NBLK - 1);

  // pending slot
  logic          pend_v;
  op_e           p_op;
  logic [BW-1:0] p_blk;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  // engine state
  logic          wr_act, wr_last;
  logic          er_act, er_all, er_tmr_act, er_last;
  logic [BW-1:0] er_blk;
  logic          err_q, lv_q;
  logic [NBLK-1:0] locks;

  // named internal events
  logic accept_ev, can_go, dispatch, refuse_ev, go_ok;
  logic start_wr, start_er, start_ea, set_lk, clr_lk, clr_st, bad_op;
  logic er_susp, er_sel, er_skip, er_load, er_end_blk, er_done_all;

  assign req_ready = !pend_v && rp_n;
  assign accept_ev = req_valid && req_ready;

  always_comb begin
    unique case (p_op)
      OP_WRITE:                  can_go = !wr_act && !(er_act && (er_all || er_blk == p_blk));
      OP_ERASE, OP_ERASE_ALL,
      OP_SET_LOCK, OP_CLR_LOCKS: can_go = !wr_act && !er_act;
      default:                   can_go = 1'b1;
    endcase
  end

  assign dispatch  = pend_v && can_go && rp_n;
  assign refuse_ev = dispatch && hits_array(p_op) && refused(locks[p_blk], wp_n);
  assign go_ok     = dispatch && !refuse_ev;
  assign start_wr  = go_ok && (p_op == OP_WRITE);
  assign start_er  = go_ok && (p_op == OP_ERASE);
  assign start_ea  = go_ok && (p_op == OP_ERASE_ALL);
  assign set_lk    = go_ok && (p_op == OP_SET_LOCK);
  assign clr_lk    = go_ok && (p_op == OP_CLR_LOCKS);
  assign clr_st    = go_ok && (p_op == OP_CLR_STAT);
  assign bad_op    = dispatch && undefined_op(p_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      p_op   <= OP_RSV0;
      p_blk  <= '0;
      p_addr <= '0;
      p_data <= '0;
    end else if (!rp_n) begin
      pend_v <= 1'b0;
    end else if (accept_ev) begin
      pend_v <= 1'b1;
      p_op   <= op_e'(req_op);
      p_blk  <= req_blk;
      p_addr <= req_addr;
      p_data <= req_data;
    end else if (dispatch) begin
      pend_v <= 1'b0;
    end
  end

  qop_lockbank #(.NBLK(NBLK), .BW(BW)) u_locks (
    .clk(clk), .rst_n(rst_n), .set_en(set_lk), .set_idx(p_blk),
    .clr_all(clr_lk), .locks(locks)
  );

  // write engine
  qop_timer #(.CW(CW)) u_wr_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!rp_n), .load(start_wr), .len(wr_cycles),
    .hold(1'b0), .active(wr_act), .last(wr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_blk  <= '0;
      arr_addr <= '0;
      arr_data <= '0;
    end else if (start_wr) begin
      arr_blk  <= p_blk;
      arr_addr <= p_addr;
      arr_data <= p_data;
    end
  end

  // erase engine: one select cycle per block, then the countdown
  assign er_susp     = er_act && susp_req;
  assign er_sel      = er_act && !er_tmr_act && !susp_req;
  assign er_skip     = er_sel && refused(locks[er_blk], wp_n);
  assign er_load     = er_sel && !er_skip;
  assign er_end_blk  = er_skip || er_last;
  assign er_done_all = er_end_blk && (!er_all || er_blk == LAST_BLK);

  qop_timer #(.CW(CW)) u_er_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!rp_n), .load(er_load), .len(er_cycles),
    .hold(susp_req), .active(er_tmr_act), .last(er_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_act <= 1'b0;
      er_all <= 1'b0;
      er_blk <= '0;
    end else if (!rp_n) begin
      er_act <= 1'b0;
      er_all <= 1'b0;
    end else if (start_er || start_ea) begin
      er_act <= 1'b1;
      er_all <= start_ea;
      er_blk <= start_ea ? '0 : p_blk;
    end else if (er_done_all) begin
      er_act <= 1'b0;
    end else if (er_end_blk) begin
      er_blk <= er_blk + 1'b1;
    end
  end

  // sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      lv_q  <= 1'b0;
    end else if (!rp_n || clr_st) begin
      err_q <= 1'b0;
      lv_q  <= 1'b0;
    end else begin
      if (refuse_ev || bad_op) err_q <= 1'b1;
      if (refuse_ev)           lv_q  <= 1'b1;
    end
  end

  assign busy      = wr_act || (er_act && !susp_req) || pend_v;
  assign ry_by_n   = !busy || !rp_n;
  assign status    = pack_status(ry_by_n, er_susp, err_q, lv_q);
  assign lock_viol = lv_q;
  assign arr_we    = wr_last;
  assign erase_stb = er_last;
  assign erase_blk = er_blk;
endmodule

// File: rtl/qop_chk.sv
module qop_chk #(
  parameter int BW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rp_n,
  input logic          susp_req,
  input logic          req_valid,
  input logic          req_ready,
  input logic          arr_we,
  input logic          erase_stb,
  input logic          ry_by_n,
  input logic [7:0]    status,
  input logic [BW-1:0] arr_blk,
  input logic [BW-1:0] er_blk_w,
  input logic          er_act_w,
  input logic          wr_act_w,
  input logic          pend_v_w,
  input logic          refuse_w
);
  p_slot_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ry_by_n && rp_n) |-> req_ready);

  p_refuse_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_w |=> (status[5] && status[4]));

  p_overlap_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && er_act_w) |-> (arr_blk != er_blk_w));

  p_susp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (er_act_w && susp_req && !wr_act_w && !pend_v_w) |-> (ry_by_n && status[6]));

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (!arr_we && !erase_stb && status[6:0] == 7'd0));
endmodule

bind qop_ctrl qop_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .susp_req(susp_req),
  .req_valid(req_valid), .req_ready(req_ready), .arr_we(arr_we),
  .erase_stb(erase_stb), .ry_by_n(ry_by_n), .status(status),
  .arr_blk(arr_blk), .er_blk_w(er_blk), .er_act_w(er_act),
  .wr_act_w(wr_act), .pend_v_w(pend_v), .refuse_w(refuse_ev)
);

// File: tb/sim_qop_ctrl.sv
`timescale 1ns/1ps
module sim_qop_ctrl;
  localparam int WRN = 5;
  localparam int ERN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [4:0] req_blk = '0;
  logic [14:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic wp_n = 1'b1, rp_n = 1'b1, susp_req = 1'b0;
  logic [15:0] wr_cycles = 16'(WRN), er_cycles = 16'(ERN);
  logic ry_by_n, lock_viol, busy, arr_we, erase_stb;
  logic [7:0] status;
  logic [4:0] arr_blk, erase_blk;
  logic [14:0] arr_addr;
  logic [15:0] arr_data;

  qop_ctrl u0 (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event monitor sampled away from the active edge
  int we_cnt = 0, er_cnt = 0, last_we_cyc = 0, last_er_cyc = 0, ry_hi_at_we = 0;
  logic [4:0] we_log [0:63];
  logic [4:0] er_log [0:63];
  logic [14:0] last_addr;
  logic [15:0] last_data;
  always @(negedge clk) begin
    if (arr_we) begin
      we_log[we_cnt % 64] = arr_blk;
      last_addr = arr_addr; last_data = arr_data;
      last_we_cyc = cyc; we_cnt++;
      if (ry_by_n) ry_hi_at_we++;
    end
    if (erase_stb) begin
      er_log[er_cnt % 64] = erase_blk;
      last_er_cyc = cyc; er_cnt++;
    end
  end

  int n_chk = 0, n_bad = 0, acc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int op, input int blk, input int addr, input int data);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_blk = 5'(blk);
    req_addr = 15'(addr); req_data = 16'(data);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!ry_by_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ry_by_n == 1'b1, "R1 ready", ry_by_n, 1);
    chk(status == 8'h80, "R1 status", status, 8'h80);
    chk(req_ready && !arr_we && !erase_stb, "R1 handshake/strobes",
        {req_ready, arr_we, erase_stb}, 3'b100);
  endtask

  task automatic t_write();
    int w0;
    w0 = we_cnt;
    send(1, 3, 15'h123, 16'hBEEF);
    @(negedge clk);
    chk(ry_by_n == 1'b0, "R2 busy during write", ry_by_n, 0);
    wait_idle();
    chk(we_cnt == w0 + 1, "R2 one strobe", we_cnt - w0, 1);
    chk(last_we_cyc - acc == WRN, "R2 latency", last_we_cyc - acc, WRN);
    chk(we_log[w0 % 64] == 5'd3 && last_addr == 15'h123 && last_data == 16'hBEEF,
        "R2 fields", {we_log[w0 % 64], last_data}, {5'd3, 16'hBEEF});
  endtask

  task automatic t_queue();
    int w0, h0;
    w0 = we_cnt; h0 = ry_hi_at_we;
    send(1, 1, 1, 16'h1111);
    send(1, 2, 2, 16'h2222);
    chk(req_ready == 1'b0, "R3 slot full drops ready", req_ready, 0);
    send(1, 4, 3, 16'h3333);
    wait_idle();
    chk(we_cnt == w0 + 3, "R3 all writes done", we_cnt - w0, 3);
    chk(we_log[w0 % 64] == 5'd1 && we_log[(w0 + 1) % 64] == 5'd2 && we_log[(w0 + 2) % 64] == 5'd4,
        "R3 order", we_log[(w0 + 2) % 64], 4);
    chk(ry_hi_at_we == h0, "R3 ready stays low until drained", ry_hi_at_we - h0, 0);
    chk(ry_by_n == 1'b1, "R3 ready after drain", ry_by_n, 1);
  endtask

  task automatic t_erase();
    int e0;
    e0 = er_cnt;
    send(2, 7, 0, 0);
    wait_idle();
    chk(er_cnt == e0 + 1 && er_log[e0 % 64] == 5'd7, "R6 erase block",
        er_log[e0 % 64], 7);
    chk(last_er_cyc - acc == ERN + 1, "R6 latency", last_er_cyc - acc, ERN + 1);
  endtask

  task automatic t_overlap();
    int ea;
    send(2, 9, 0, 0);
    ea = acc;
    send(1, 10, 5, 16'h0A0A);
    wait_idle();
    chk(last_we_cyc < last_er_cyc, "R8 other-block write overlaps", last_we_cyc, last_er_cyc);
    chk(last_er_cyc - ea == ERN + 1, "R8 erase timing unchanged", last_er_cyc - ea, ERN + 1);
    send(2, 11, 0, 0);
    send(1, 11, 6, 16'h0B0B);
    wait_idle();
    chk(last_we_cyc > last_er_cyc, "R8 same-block write waits", last_we_cyc, last_er_cyc);
  endtask

  task automatic t_locks();
    int w0, e0;
    send(4, 5, 0, 0);
    wait_idle();
    wp_n = 1'b0;
    w0 = we_cnt; e0 = er_cnt;
    send(1, 5, 1, 16'h5555);
    wait_idle();
    repeat (WRN + 2) @(negedge clk);
    chk(we_cnt == w0, "R4 locked write refused", we_cnt - w0, 0);
    chk(status == 8'hB0 && lock_viol, "R4 flags", status, 8'hB0);
    send(2, 5, 0, 0);
    wait_idle();
    repeat (ERN + 2) @(negedge clk);
    chk(er_cnt == e0, "R4 locked erase refused", er_cnt - e0, 0);
    send(6, 0, 0, 0);
    wait_idle();
    chk(status == 8'h80, "R11 clear status", status, 8'h80);
    wp_n = 1'b1;
    send(1, 5, 2, 16'h5A5A);
    wait_idle();
    chk(we_cnt == w0 + 1 && we_log[w0 % 64] == 5'd5, "R5 protect off bypasses lock",
        we_cnt - w0, 1);
  endtask

  task automatic t_undef();
    int w0, e0;
    w0 = we_cnt; e0 = er_cnt;
    send(7, 1, 0, 0);
    wait_idle();
    chk(status == 8'hA0, "R12 undefined opcode 7", status, 8'hA0);
    send(0, 1, 0, 0);
    wait_idle();
    chk(status == 8'hA0 && we_cnt == w0 && er_cnt == e0, "R12 undefined opcode 0",
        status, 8'hA0);
    send(6, 0, 0, 0);
    wait_idle();
    chk(status == 8'h80, "R11 clear after error", status, 8'h80);
  endtask

  task automatic t_suspend();
    int e0;
    e0 = er_cnt;
    send(2, 12, 0, 0);
    repeat (3) @(negedge clk);
    susp_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(status == 8'hC0, "R9 suspended status and ready", status, 8'hC0);
    repeat (20) @(negedge clk);
    chk(er_cnt == e0, "R9 erase frozen", er_cnt - e0, 0);
    susp_req = 1'b0;
    wait_idle();
    chk(er_cnt == e0 + 1 && er_log[e0 % 64] == 5'd12, "R9 resume completes",
        er_cnt - e0, 1);
    chk(last_er_cyc - acc == ERN + 1 + 22, "R9 resumes where stopped",
        last_er_cyc - acc, ERN + 23);
  endtask

  task automatic t_erase_all();
    int e0, bad, k;
    send(4, 0, 0, 0);
    send(4, 31, 0, 0);
    wait_idle();
    wp_n = 1'b0;
    e0 = er_cnt;
    send(3, 0, 0, 0);
    wait_idle();
    chk(er_cnt == e0 + 29, "R7 strobe count skips locked", er_cnt - e0, 29);
    bad = 0; k = 0;
    for (int b = 0; b < 32; b++) begin
      if (b == 0 || b == 5 || b == 31) continue;
      if (er_log[(e0 + k) % 64] != 5'(b)) bad++;
      k++;
    end
    chk(bad == 0, "R7 ascending order", bad, 0);
    chk(status == 8'h80, "R7 skip raises no flag", status, 8'h80);
  endtask

  task automatic t_abort();
    int w0, e0;
    wp_n = 1'b1;
    send(2, 2, 0, 0);
    send(1, 2, 7, 16'h7777);
    @(negedge clk);
    rp_n = 1'b0;
    w0 = we_cnt; e0 = er_cnt;
    @(negedge clk);
    chk(!req_ready && ry_by_n && status == 8'h80, "R10 abort state",
        {req_ready, ry_by_n, status}, {2'b01, 8'h80});
    repeat (2) @(negedge clk);
    rp_n = 1'b1;
    repeat (WRN + ERN + 20) @(negedge clk);
    chk(we_cnt == w0 && er_cnt == e0, "R10 nothing after abort",
        we_cnt - w0 + er_cnt - e0, 0);
    wp_n = 1'b0;
    send(1, 5, 0, 16'h1234);
    wait_idle();
    repeat (WRN + 2) @(negedge clk);
    chk(we_cnt == w0 && status == 8'hB0, "R10 locks retained", status, 8'hB0);
    send(6, 0, 0, 0);
    wait_idle();
  endtask

  task automatic t_clr_locks();
    int w0;
    send(5, 0, 0, 0);
    wait_idle();
    w0 = we_cnt;
    send(1, 5, 9, 16'h9999);
    wait_idle();
    chk(we_cnt == w0 + 1 && status == 8'h80, "R13 clear locks", we_cnt - w0, 1);
    wp_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_queue();
    t_erase();
    t_overlap();
    t_locks();
    t_undef();
    t_suspend();
    t_erase_all();
    t_abort();
    t_clr_locks();
    finish_run();
  end
endmodule